// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a successive-approximation analog-to-digital converter with a 10-bit search register. A one-clock start request from standby makes it busy. It first opens the sample-and-hold switch for a fixed number of clocks. It then closes the switch to hold the sample and runs a binary search. On each search step it sends a trial code to the resistor-string tap selector and reads one comparator bit back.

When the last bit is decided, the code is written into two result registers. One holds the upper byte and the other holds the two least significant bits. In the same cycle a one-clock conversion-end interrupt fires and the busy/start flag drops, which returns the block to standby. A short-resolution mode stops the search two bits early. In that mode the whole 8-bit result goes into the upper-byte register and the two-bit register is left as it was. The analog comparator, tap ladder and input multiplexer sit outside the block.

All pins are plain control and status signals. There is no streaming interface, so no back-pressure applies. Results stay readable until the next conversion overwrites them.

Top module: `adc_sar_ctrl`

## Requirements
- R1: A synchronous reset leaves `busy`, `sh_sample` and `eoc_irq` at 0 and clears `res_hi` and `res_lo` to zero. Asserting it during a conversion abandons that conversion.
- R2: A `start_req` seen at a clock edge while in standby sets `busy` from the next cycle. `sh_sample` is 1 for exactly SAMPLE_CLKS cycles after that edge, then 0 (hold) until the conversion ends.
- R3: In the first cycle after sampling, `dac_code` is 10'h200, which has only bit 9 set.
- R4: Each search step decides one bit, from bit 9 downward. The bit under test stays 1 when `cmp_ge` is 1 (held input at or above the tap) and becomes 0 otherwise, and the next lower bit is set to 1. `dac_code` always shows the decided upper bits, the current trial bit and zeros below it. With an ideal comparator the result equals the input code.
- R5: In 10-bit mode (`res8_mode`=0 at start), `eoc_irq` is high in the cycle SAMPLE_CLKS+10 cycles after the cycle in which `busy` first reads 1.
- R6: In 10-bit mode, `res_hi` receives result bits 9:2 and `res_lo` receives bits 1:0.
- R7: `eoc_irq` lasts exactly one cycle. In that cycle the new results are already visible and `busy` is 0. Outside that moment, the results do not change while idle.
- R8: With `res8_mode`=1 sampled at start, the search ends once bit 2 is decided. `eoc_irq` appears SAMPLE_CLKS+8 cycles after `busy` first reads 1, `res_hi` holds the 8-bit result, and `res_lo` is not modified.
- R9: A `start_req` while `busy` is 1 is ignored: the conversion keeps its timing and result and does not restart afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Start request, acted on only in standby |
| res8_mode | input | 1 | 1 selects 8-bit resolution, sampled at start |
| cmp_ge | input | 1 | Comparator: 1 when the held input is at or above the tap |
| busy | output | 1 | Start/status flag, self-clearing at conversion end |
| sh_sample | output | 1 | 1 = sample-and-hold tracking, 0 = holding |
| dac_code | output | 10 | Trial code to the tap selector |
| res_hi | output | 8 | Upper result byte |
| res_lo | output | 2 | Lower two result bits |
| eoc_irq | output | 1 | One-clock conversion-end interrupt |

## Verification
An ideal comparator model converts every one of the 1024 input codes in both resolutions. This shows that each decided bit follows the comparator and that no bit is skipped or decided twice. It also confirms the high/low split and the 8-bit truncation with the low register untouched. The end points 0 and 1023, plus the codes next to each power of two, separate a wrong comparison direction from an off-by-one in the step index. Separate runs place start requests inside the sampling and search phases, and assert reset mid-conversion. These show that timing and result are not disturbed by a late start, and that reset really aborts.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_SEARCH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_sample_timer.sv
// Counts the sampling window; expire marks its final cycle.
module adc_sample_timer #(
  parameter int SAMPLE_CLKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(SAMPLE_CLKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == CW'(SAMPLE_CLKS - 1));
endmodule

// File: rtl/adc_sar_search.sv
// Binary-search trial register: one bit decided per step, MSB first.
module adc_sar_search #(
  parameter int RES_W   = 10,
  parameter int SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             short_mode,
  input  logic             cmp_ge,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] final_code,
  output logic             last
);
  localparam int IW     = $clog2(RES_W);
  localparam int LO_W   = RES_W - SHORT_W;

  logic [IW-1:0] idx_q;
  logic [IW-1:0] stop_idx;

  assign stop_idx = short_mode ? IW'(LO_W) : '0;
  assign last     = (idx_q == stop_idx);

  always_ff @(posedge clk) begin
    if (rst)       idx_q <= '0;
    else if (load) idx_q <= IW'(RES_W - 1);
    else if (step && !last) idx_q <= idx_q - 1'b1;
  end

  for (genvar i = 0; i < RES_W; i++) begin : g_bit
    logic is_cur;
    logic is_next;
    assign is_cur        = (idx_q == IW'(i));
    assign is_next       = (idx_q == IW'(i + 1)) && !last;
    assign final_code[i] = is_cur ? cmp_ge : trial[i];

    always_ff @(posedge clk) begin
      if (rst)       trial[i] <= 1'b0;
      else if (load) trial[i] <= (i == RES_W - 1);
      else if (step) trial[i] <= final_code[i] | is_next;
    end
  end
endmodule

// File: rtl/adc_result_regs.sv
// Split result storage: upper byte always, low bits only at full resolution.
module adc_result_regs #(
  parameter int RES_W   = 10,
  parameter int SHORT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               latch,
  input  logic               short_mode,
  input  logic [RES_W-1:0]   code,
  output logic [SHORT_W-1:0] hi,
  output logic [RES_W-SHORT_W-1:0] lo
);
  localparam int LO_W = RES_W - SHORT_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= '0;
      lo <= '0;
    end else if (latch) begin
      hi <= code[RES_W-1 -: SHORT_W];
      if (!short_mode) lo <= code[LO_W-1:0];
    end
  end
endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int SHORT_W     = 8,
  parameter int SAMPLE_CLKS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_req,
  input  logic                     res8_mode,
  input  logic                     cmp_ge,
  output logic                     busy,
  output logic                     sh_sample,
  output logic [RES_W-1:0]         dac_code,
  output logic [SHORT_W-1:0]       res_hi,
  output logic [RES_W-SHORT_W-1:0] res_lo,
  output logic                     eoc_irq
);
  seq_state_e           state_q;
  logic                 mode8_q;
  logic                 expire;
  logic                 step;
  logic                 last;
  logic                 finish;
  logic [RES_W-1:0]     trial;
  logic [RES_W-1:0]     final_code;

  assign step   = (state_q == ST_SEARCH);
  assign finish = step && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode8_q <= 1'b0;
      eoc_irq <= 1'b0;
    end else begin
      eoc_irq <= finish;
      unique case (state_q)
        ST_IDLE: if (start_req) begin
          state_q <= ST_SAMPLE;
          mode8_q <= res8_mode;
        end
        ST_SAMPLE: if (expire) state_q <= ST_SEARCH;
        ST_SEARCH: if (last)   state_q <= ST_IDLE;
        default:               state_q <= ST_IDLE;
      endcase
    end
  end

  adc_sample_timer #(.SAMPLE_CLKS(SAMPLE_CLKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (state_q == ST_SAMPLE),
    .expire (expire)
  );

  adc_sar_search #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_search (
    .clk        (clk),
    .rst        (rst),
    .load       (expire),
    .step       (step),
    .short_mode (mode8_q),
    .cmp_ge     (cmp_ge),
    .trial      (trial),
    .final_code (final_code),
    .last       (last)
  );

  adc_result_regs #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_res (
    .clk        (clk),
    .rst        (rst),
    .latch      (finish),
    .short_mode (mode8_q),
    .code       (final_code),
    .hi         (res_hi),
    .lo         (res_lo)
  );

  assign busy      = (state_q != ST_IDLE);
  assign sh_sample = (state_q == ST_SAMPLE);
  assign dac_code  = trial;
endmodule

// File: rtl/adc_sar_ctrl_chk.sv
module adc_sar_ctrl_chk #(
  parameter int RES_W   = 10,
  parameter int SHORT_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     start_req,
  input logic                     busy,
  input logic                     sh_sample,
  input logic [RES_W-1:0]         dac_code,
  input logic [SHORT_W-1:0]       res_hi,
  input logic [RES_W-SHORT_W-1:0] res_lo,
  input logic                     eoc_irq
);
  AST_SAMPLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    sh_sample |-> busy); // R2
  AST_NO_RESAMPLE: assert property (@(posedge clk) disable iff (rst)
    (busy && !sh_sample) |=> !sh_sample); // R9
  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (rst)
    ($fell(sh_sample) && busy) |-> (dac_code == (RES_W'(1) << (RES_W - 1)))); // R3
  AST_EOC_PULSE: assert property (@(posedge clk) disable iff (rst)
    eoc_irq |=> !eoc_irq); // R7
  AST_EOC_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    eoc_irq |-> (!busy && $past(busy))); // R7
  AST_RES_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !eoc_irq) |-> ($stable(res_hi) && $stable(res_lo))); // R7
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start_req && !busy) |=> (busy && sh_sample)); // R2
endmodule

bind adc_sar_ctrl adc_sar_ctrl_chk #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_req (start_req),
  .busy      (busy),
  .sh_sample (sh_sample),
  .dac_code  (dac_code),
  .res_hi    (res_hi),
  .res_lo    (res_lo),
  .eoc_irq   (eoc_irq)
);

// File: tb/test_adc_sar_ctrl.sv
module test_adc_sar_ctrl;
  localparam int S = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_req = 1'b0;
  logic       res8_mode = 1'b0;
  logic       cmp_ge;
  logic       busy, sh_sample, eoc_irq;
  logic [9:0] dac_code;
  logic [7:0] res_hi;
  logic [1:0] res_lo;
  int         vin = 0;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  // ideal comparator: held code vs tap code
  assign cmp_ge = (vin >= int'(dac_code));

  adc_sar_ctrl #(.SAMPLE_CLKS(S)) i_adc_sar_ctrl (
    .clk(clk), .rst(rst), .start_req(start_req), .res8_mode(res8_mode),
    .cmp_ge(cmp_ge), .busy(busy), .sh_sample(sh_sample), .dac_code(dac_code),
    .res_hi(res_hi), .res_lo(res_lo), .eoc_irq(eoc_irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One conversion; late_start pokes start_req during busy (R9).
  task automatic convert(input int v, input bit m8, input bit late_start);
    int samples = 0;
    int eoc_at = -1;
    int first_dac = -1;
    int prev_lo = int'(res_lo);
    int exp_at = m8 ? S + 8 : S + 10;
    vin = v;
    res8_mode = m8;
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    res8_mode = ~m8;
    for (int cyc = 0; cyc < 60; cyc++) begin
      if (sh_sample) samples++;
      if (cyc == S) first_dac = int'(dac_code);
      if (eoc_irq) begin
        eoc_at = cyc;
        chk("R7", "busy at eoc", int'(busy), 0);
        if (m8) begin
          chk("R8", "res_hi 8-bit", int'(res_hi), v >> 2);
          chk("R8", "res_lo kept", int'(res_lo), prev_lo);
        end else begin
          chk("R4", "result", int'({res_hi, res_lo}), v);
          chk("R6", "res_lo", int'(res_lo), v & 3);
        end
        break;
      end
      start_req = late_start && (cyc == 2 || cyc == S + 3);
      @(negedge clk);
      start_req = 1'b0;
    end
    chk(m8 ? "R8" : "R5", "eoc cycle", eoc_at, exp_at);
    chk("R2", "sample cycles", samples, S);
    chk("R3", "first trial", first_dac, 512);
    @(negedge clk);
    chk("R7", "eoc width", int'(eoc_irq), 0);
    if (late_start) chk("R9", "no restart", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "sample", int'(sh_sample), 0);
    chk("R1", "eoc", int'(eoc_irq), 0);
    chk("R1", "results", int'({res_hi, res_lo}), 0);

    // full sweep at both resolutions
    for (int v = 0; v < 1024; v++) convert(v, 1'b0, 1'b0);
    convert(1023, 1'b0, 1'b0);
    for (int v = 0; v < 1024; v++) convert(v, 1'b1, 1'b0);
    // R8: low bits kept from a prior 10-bit run
    convert(10'h1, 1'b0, 1'b0);
    convert(10'h3FE, 1'b1, 1'b0);
    chk("R8", "res_lo after 8-bit", int'(res_lo), 1);

    // R9: start pokes mid-conversion
    convert(10'h155, 1'b0, 1'b1);
    convert(10'h2AA, 1'b1, 1'b1);
    convert(10'h200, 1'b0, 1'b1);

    // R1: reset mid-conversion
    vin = 700;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    repeat (S + 3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1", "busy after abort", int'(busy), 0);
    chk("R1", "sample after abort", int'(sh_sample), 0);
    chk("R1", "results after abort", int'({res_hi, res_lo}), 0);
    repeat (15) @(negedge clk);
    chk("R1", "no late eoc", int'(eoc_irq), 0);
    chk("R1", "stays idle", int'(busy), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule